// File: doc/BRIEF.md
# Read Pulse Time-Domain Qualifier

This block sits at the end of a disk read channel. It takes the digitised output of the crosspoint comparator and turns it into clean read-data pulses. It uses two counters that run from the system clock. The comparator level first passes through a synchroniser. Each change of the synchronised level then opens a qualification window. If the level is back at the value it had before the window opened when the window runs out, the change was noise and nothing is emitted. Otherwise the second counter produces one output pulse of fixed width.

The window length follows an active-low density select: a low level picks the high-density recording rate and the shorter window. The block drives read data only while the drive is reading, meaning the write gate, the erase gate and the power-save input are all high. While any of them is low, the output is forced low and both counters are cleared.

Top module: `rdq_qualifier`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `rd_pulse` is low and no window or pulse is in progress.
- R2: A change of `cmp_in` in either direction that is still in place when its window ends produces exactly one pulse. If the change is made between clock edges, `rd_pulse` rises on the (N+3)-th rising edge after it, where N is the window length in cycles (two synchroniser stages, one edge register, then N window cycles).
- R3: Every read-data pulse is high for exactly `PULSE_LEN` clock cycles.
- R4: The window length is `LEN_1M` cycles when `dens_n` is high and `LEN_2M` cycles when `dens_n` is low. The level is taken at the transition that loads the window.
- R5: If `cmp_in` returns to its pre-window level and that return reaches the edge detector before the window ends, no pulse is produced. A return arriving on the expiry cycle itself still cancels the event; a change held for N+1 cycles or longer is emitted.
- R6: A transition during an open window restarts the window with a fresh length and keeps the original pre-window level for comparison. A surviving event is then timed from the last transition.
- R7: While `wgate_n` or `egate_n` is low, `rd_pulse` is low. This takes effect combinationally, including in the middle of a pulse.
- R8: While `psave_n` is low, `rd_pulse` is low and comparator transitions produce no pulse.
- R9: Leaving read mode clears both counters. A window or pulse that was in progress when read mode was left does not produce output after read mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Asynchronous comparator level from the read channel |
| dens_n | input | 1 | Density select; low picks the short window |
| wgate_n | input | 1 | Write gate, active low |
| egate_n | input | 1 | Erase gate, active low |
| psave_n | input | 1 | Power save, active low |
| rd_pulse | output | 1 | Qualified read-data pulse, active high |

## Verification
The assertions assume that `cmp_in` is low while reset is high. The synchroniser flops reset to zero, so a high level present at reset release would look like a genuine transition. They also assume that every input changes away from the rising clock edge. The bench holds the comparator low through reset and drives every input on the falling edge, so each change is seen at one known rising edge. Under these conditions the exact rise cycles in R2 and R6 are deterministic.

// File: rtl/rdq_pkg.sv
package rdq_pkg;

    // Density select as seen on the pin: low means the high-density rate.
    typedef enum logic {
        DENS_HIGH = 1'b0,
        DENS_LOW  = 1'b1
    } density_e;

    // Synchronised comparator view handed from the edge stage to the window.
    typedef struct packed {
        logic edge_hit;   // level differs from the one registered a cycle earlier
        logic level;      // current synchronised level
        logic prior;      // level before this cycle's change
    } cmp_event_t;

    function automatic int unsigned window_for(density_e d,
                                               int unsigned len_low,
                                               int unsigned len_high);
        return (d == DENS_HIGH) ? len_high : len_low;
    endfunction

    function automatic int unsigned cnt_bits(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rdq_sync_edge.sv
module rdq_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 din,
    output rdq_pkg::cmp_event_t  ev
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its delayed copy.
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], din};
        end
    end

    assign ev.edge_hit = chain[STAGES] ^ chain[STAGES-1];
    assign ev.level    = chain[STAGES-1];
    assign ev.prior    = chain[STAGES];

endmodule

// File: rtl/rdq_window.sv
module rdq_window #(
    parameter int unsigned LEN_1M = 123,
    parameter int unsigned LEN_2M = 63,
    parameter int unsigned CW     = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  rdq_pkg::density_e    dens,
    input  rdq_pkg::cmp_event_t  ev,
    output logic                 active,
    output logic                 fire
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;
    logic          base;      // level held before the first transition of this window

    assign load_val = CW'(rdq_pkg::window_for(dens, LEN_1M, LEN_2M));
    assign active   = (cnt != '0);

    // Last window cycle with no new transition: emit only if the level moved away.
    assign fire = active && (cnt == CW'(1)) && !ev.edge_hit && (ev.level != base);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt  <= '0;
            base <= 1'b0;
        end else if (ev.edge_hit) begin
            cnt <= load_val;
            if (!active) begin
                base <= ev.prior;
            end
        end else if (active) begin
            cnt <= cnt - CW'(1);
        end
    end

endmodule

// File: rtl/rdq_pulse.sv
module rdq_pulse #(
    parameter int unsigned PULSE_LEN = 20,
    parameter int unsigned PB        = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic fire,
    output logic busy
);
    logic [PB-1:0] left;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            left <= '0;
        end else if (fire) begin
            left <= PB'(PULSE_LEN);
        end else if (left != '0) begin
            left <= left - PB'(1);
        end
    end

    assign busy = (left != '0);

endmodule

// File: rtl/rdq_qualifier.sv
module rdq_qualifier #(
    parameter int unsigned LEN_1M      = 123,
    parameter int unsigned LEN_2M      = 63,
    parameter int unsigned PULSE_LEN   = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_in,
    input  logic dens_n,
    input  logic wgate_n,
    input  logic egate_n,
    input  logic psave_n,
    output logic rd_pulse
);
    localparam int unsigned WIN_MAX  = (LEN_1M > LEN_2M) ? LEN_1M : LEN_2M;
    localparam int unsigned WIN_BITS = rdq_pkg::cnt_bits(WIN_MAX);
    localparam int unsigned PUL_BITS = rdq_pkg::cnt_bits(PULSE_LEN);

    rdq_pkg::cmp_event_t ev;
    logic read_en;
    logic win_active;
    logic fire;
    logic busy;

    assign read_en = wgate_n & egate_n & psave_n;

    rdq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (cmp_in),
        .ev  (ev)
    );

    rdq_window #(.LEN_1M(LEN_1M), .LEN_2M(LEN_2M), .CW(WIN_BITS)) u_window (
        .clk    (clk),
        .rst    (rst),
        .enable (read_en),
        .dens   (rdq_pkg::density_e'(dens_n)),
        .ev     (ev),
        .active (win_active),
        .fire   (fire)
    );

    rdq_pulse #(.PULSE_LEN(PULSE_LEN), .PB(PUL_BITS)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .enable (read_en),
        .fire   (fire),
        .busy   (busy)
    );

    assign rd_pulse = busy & read_en;

endmodule

// File: rtl/rdq_qualifier_chk.sv
module rdq_qualifier_chk #(
    parameter int unsigned PULSE_LEN = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wgate_n,
    input  logic                egate_n,
    input  logic                psave_n,
    input  logic                rd_pulse,
    input  logic                win_active,
    input  logic                fire,
    input  rdq_pkg::cmp_event_t ev
);
    localparam int unsigned RB = $clog2(PULSE_LEN + 2);

    logic          read_ok;
    logic [RB-1:0] hi_run;

    assign read_ok = wgate_n & egate_n & psave_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
        end else if (!rd_pulse) begin
            hi_run <= '0;
        end else if (hi_run != '1) begin
            hi_run <= hi_run + RB'(1);
        end
    end

    // R3: no pulse lasts longer than the programmed width.
    a_r3_width_cap: assert property (@(posedge clk) disable iff (rst)
        (32'(hi_run) <= PULSE_LEN));

    // R2: the output rises only on the cycle after a window has qualified an event.
    a_r2_rise_after_window: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_pulse) |-> $past(fire));

    // R6: a transition seen in read mode always leaves a window open next cycle.
    a_r6_edge_arms_window: assert property (@(posedge clk) disable iff (rst)
        (ev.edge_hit && read_ok) |=> win_active);

    // R9: leaving read mode empties the window and the pulse timer.
    a_r9_mode_exit_clears: assert property (@(posedge clk) disable iff (rst)
        !read_ok |=> (!win_active && !rd_pulse));

endmodule

bind rdq_qualifier rdq_qualifier_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wgate_n    (wgate_n),
    .egate_n    (egate_n),
    .psave_n    (psave_n),
    .rd_pulse   (rd_pulse),
    .win_active (win_active),
    .fire       (fire),
    .ev         (ev)
);

// File: tb/rdq_qualifier_bench.sv
module rdq_qualifier_bench;
    localparam int L1 = 12;
    localparam int L2 = 7;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmp = 1'b0;
    logic dens_n = 1'b1;
    logic wg = 1'b1;
    logic eg = 1'b1;
    logic ps = 1'b1;
    logic rd;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rdq_qualifier #(.LEN_1M(L1), .LEN_2M(L2), .PULSE_LEN(PW)) u_rdq_qualifier (
        .clk      (clk),
        .rst      (rst),
        .cmp_in   (cmp),
        .dens_n   (dens_n),
        .wgate_n  (wg),
        .egate_n  (eg),
        .psave_n  (ps),
        .rd_pulse (rd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int win_len(input logic dn);
        return dn ? L1 : L2;
    endfunction

    // Toggle cmp now (index 0) and again at indices t1, t2 (0 = unused).
    // Returns the index of the first high sample and the length of that pulse.
    task automatic watch(input int limit, input int t1, input int t2,
                         output int rise, output int width);
        bit in_first;
        rise = 0;
        width = 0;
        in_first = 1'b0;
        cmp = ~cmp;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (rd && rise == 0) begin
                rise = i;
                in_first = 1'b1;
            end
            if (in_first) begin
                if (rd) width++;
                else in_first = 1'b0;
            end
            if ((t1 != 0 && i == t1) || (t2 != 0 && i == t2)) cmp = ~cmp;
        end
    endtask

    task automatic quiet(input int limit, output int highs);
        highs = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (rd) highs++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int rise;
        int width;
        int highs;
        int n;

        repeat (3) @(negedge clk);
        check(rd == 1'b0, "R1 output in reset", int'(rd), 0);
        rst = 1'b0;
        @(negedge clk);
        check(rd == 1'b0, "R1 output after reset", int'(rd), 0);
        quiet(30, highs);
        check(highs == 0, "R1 idle after reset", highs, 0);

        for (int m = 0; m < 2; m++) begin
            dens_n = (m == 0) ? 1'b1 : 1'b0;
            n = win_len(dens_n);

            // Both polarities of a clean transition.
            for (int p = 0; p < 2; p++) begin
                watch(n + PW + 8, 0, 0, rise, width);
                check(rise == n + 3, "R2/R4 rise cycle", rise, n + 3);
                check(width == PW, "R3 pulse width", width, PW);
            end

            // Glitch sweep: return after g cycles.
            for (int g = 1; g <= n + 1; g++) begin
                watch(g + n + PW + 10, g, 0, rise, width);
                if (g <= n) check(rise == 0, "R5 glitch rejected", rise, 0);
                else        check(rise == n + 3, "R5 held change emitted", rise, n + 3);
            end

            // Restart sweep: three transitions, final level differs from baseline.
            for (int g1 = 1; g1 <= n; g1++) begin
                for (int g2 = 1; g2 <= n; g2++) begin
                    watch(g1 + g2 + n + PW + 8, g1, g1 + g2, rise, width);
                    check(rise == g1 + g2 + n + 3, "R6 restart timing", rise, g1 + g2 + n + 3);
                    check(width == PW, "R6 single pulse width", width, PW);
                end
            end

            // Gates held low during a transition.
            for (int k = 0; k < 3; k++) begin
                wg = (k != 0);
                eg = (k != 1);
                ps = (k != 2);
                watch(n + PW + 10, 0, 0, rise, width);
                if (k == 2) check(rise == 0, "R8 power save blocks", rise, 0);
                else        check(rise == 0, "R7 gate blocks", rise, 0);
                wg = 1'b1;
                eg = 1'b1;
                ps = 1'b1;
                quiet(4, highs);
                check(highs == 0, "R9 no output on return", highs, 0);
            end

            // Window interrupted early.
            cmp = ~cmp;
            repeat (4) @(negedge clk);
            wg = 1'b0;
            repeat (2) @(negedge clk);
            wg = 1'b1;
            quiet(2 * n + PW + 8, highs);
            check(highs == 0, "R9 window cleared early", highs, 0);

            // Window interrupted on its last cycle.
            cmp = ~cmp;
            repeat (n + 2) @(negedge clk);
            ps = 1'b0;
            @(negedge clk);
            ps = 1'b1;
            quiet(2 * n + PW + 8, highs);
            check(highs == 0, "R9 window cleared at expiry", highs, 0);

            // Pulse interrupted.
            cmp = ~cmp;
            repeat (n + 3) @(negedge clk);
            check(rd == 1'b1, "R2 pulse present", int'(rd), 1);
            eg = 1'b0;
            #1;
            check(rd == 1'b0, "R7 pulse cut at once", int'(rd), 0);
            @(negedge clk);
            eg = 1'b1;
            quiet(PW + 4, highs);
            check(highs == 0, "R9 pulse cleared", highs, 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule